// File: doc/BRIEF.md
# Timer Interrupt Priority Vector Generator

This block merges the interrupt flags of a small timer into one prioritized interrupt request. A set of capture/compare channels (four by default) and one counter-wrap event each own a sticky flag. A channel flag is raised either by its capture event or by its compare-equal event, as that channel's mode input selects. The wrap flag is raised either when the counter hits its all-ones top or when it matches the period register, as the counting-mode input selects. Each flag has its own enable bit. Only flags that are both set and enabled take part in the combined request and in the priority decision.

The block drives one interrupt request line. It also presents a read-only 16-bit vector word that names the highest-priority pending source as an even offset. Software adds this offset to a jump-table base, and a word of zero means nothing is pending. An interrupt-accept strobe, or a read of the vector word, clears only the flag that currently wins. Lower-priority flags stay set and raise the request again. Software may also load all flags directly, which is meant for test use. An optional input synchronizer stage, chosen by parameter, registers the raw events before they reach the flags.

Top module: `tmr_irq_vec`

## Requirements
- R1: A synchronous active-high reset clears every flag. While reset is applied and right after it, `irq_req` is 0 and `vec_word` is 0.
- R2: Flag bit i (i = 0..NUM_CH-1) belongs to channel i+1. When `ch_cap_mode[i]` is 1, only `ch_cap_evt[i]` sets it; when 0, only `ch_cmp_evt[i]` sets it, and the event of the other kind has no effect. With SYNC_EVT=1, an event sampled at one clock edge makes the flag visible after the following edge.
- R3: Flag bit NUM_CH is the wrap flag. When `wrap_at_period` is 0 it is set by `cnt_at_max`; when 1 it is set by `cnt_at_period`, and the other input has no effect. The latency is the same as in R2.
- R4: `irq_req` is 1 exactly when some flag bit is set and has its `src_en` bit at 1. A flag that is set but disabled neither raises the request nor affects the vector.
- R5: Fixed priority applies: bit 0 (channel 1) is highest and bit NUM_CH (wrap) is lowest. The winning bit k gives vector value 2*(k+1). With defaults this is 2, 4, 6 and 8 for channels 1 to 4 and 10 for the wrap flag, and 12 is never produced.
- R6: `vec_word` has bit 0 and bits 15..4 at 0, and it carries the code in bits 3..1. Its value is 0 exactly when `irq_req` is 0.
- R7: A cycle with `irq_ack`=1 clears only the winning flag. All other flags keep their value, and the request stays high if any enabled flag remains.
- R8: A cycle with `vec_rd`=1 has the same clearing effect as `irq_ack`.
- R9: If a set event for a flag takes effect in the same cycle as a clear of that flag, by accept, by read or by a direct write of 0, the flag ends up set.
- R10: With `flag_wr_en`=1, the flags load `flag_wr_data` on the next edge. This write takes precedence over an accept or read clear in the same cycle.
- R11: An accept or read while nothing is pending and enabled changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_cap_mode | input | NUM_CH | Per channel: 1 selects capture events, 0 selects compare events |
| ch_cap_evt | input | NUM_CH | Per-channel capture event pulses |
| ch_cmp_evt | input | NUM_CH | Per-channel compare-equal pulses |
| wrap_at_period | input | 1 | 1: wrap flag follows the period match; 0: it follows the all-ones top |
| cnt_at_max | input | 1 | Counter reached all-ones |
| cnt_at_period | input | 1 | Counter equals the period register |
| src_en | input | NUM_CH+1 | Per-source enable; bit NUM_CH is the wrap source |
| flag_wr_en | input | 1 | Direct flag write strobe |
| flag_wr_data | input | NUM_CH+1 | Value loaded into the flags on a direct write |
| irq_ack | input | 1 | Interrupt accepted strobe |
| vec_rd | input | 1 | Vector word read strobe |
| irq_req | output | 1 | Combined interrupt request |
| vec_word | output | VEC_W | Vector word, code in bits 3..1 |
| flags | output | NUM_CH+1 | Current flag state |

## Verification
The bench builds the block with the default parameters: four channels, a 16-bit vector word and the synchronizer stage turned on. With these values every vector code from 2 to 10 can be reached, the unused code 12 stays out of reach, and the one extra cycle of event latency is visible. That extra cycle lets the bench line up a synchronized set exactly with a same-cycle accept, which is how it shows that a set wins over a clear. The table walk covers mixed enable masks and alternates between accepting and reading, so that both clear paths meet every priority position.

// File: rtl/tiv_pkg.sv
package tiv_pkg;

   // index width of a one-of-n selector, never below one bit
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // bits needed for the code field: values 0 (idle) .. n
   function automatic int code_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/tiv_flag_cell.sv
module tiv_flag_cell #(
   parameter bit SYNC_EVT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic evt,
   input  logic clr,
   input  logic wr_en,
   input  logic wr_val,
   output logic flag
);

   logic set_now;

   generate
      if (SYNC_EVT) begin : g_sync
         logic evt_q;
         always_ff @(posedge clk) begin
            if (rst) evt_q <= 1'b0;
            else     evt_q <= evt;
         end
         assign set_now = evt_q;
      end else begin : g_direct
         assign set_now = evt;
      end
   endgenerate

   // set beats write, write beats service clear
   always_ff @(posedge clk) begin
      if (rst)          flag <= 1'b0;
      else if (set_now) flag <= 1'b1;
      else if (wr_en)   flag <= wr_val;
      else if (clr)     flag <= 1'b0;
   end

endmodule

// File: rtl/tiv_prio_enc.sv
module tiv_prio_enc import tiv_pkg::*; #(
   parameter int N     = 5,
   localparam int IDX_W = sel_width(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   // lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/tiv_vec_fmt.sv
module tiv_vec_fmt import tiv_pkg::*; #(
   parameter int N      = 5,
   parameter int VEC_W  = 16,
   localparam int IDX_W  = sel_width(N),
   localparam int CODE_W = code_width(N)
) (
   input  logic             any,
   input  logic [IDX_W-1:0] idx,
   output logic [VEC_W-1:0] vec
);

   logic [CODE_W-1:0] code;

   always_comb begin
      code = any ? (CODE_W'(idx) + CODE_W'(1)) : '0;
      vec  = '0;
      vec[CODE_W:1] = code;
   end

endmodule

// File: rtl/tmr_irq_vec.sv
module tmr_irq_vec import tiv_pkg::*; #(
   parameter int NUM_CH   = 4,
   parameter int VEC_W    = 16,
   parameter bit SYNC_EVT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] ch_cap_mode,
   input  logic [NUM_CH-1:0] ch_cap_evt,
   input  logic [NUM_CH-1:0] ch_cmp_evt,
   input  logic              wrap_at_period,
   input  logic              cnt_at_max,
   input  logic              cnt_at_period,
   input  logic [NUM_CH:0]   src_en,
   input  logic              flag_wr_en,
   input  logic [NUM_CH:0]   flag_wr_data,
   input  logic              irq_ack,
   input  logic              vec_rd,
   output logic              irq_req,
   output logic [VEC_W-1:0]  vec_word,
   output logic [NUM_CH:0]   flags
);

   localparam int NUM_SRC = NUM_CH + 1;
   localparam int IDX_W   = sel_width(NUM_SRC);
   localparam int CODE_W  = code_width(NUM_SRC);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("tmr_irq_vec: NUM_CH must be at least 1");
      end
      if (CODE_W + 1 > VEC_W) begin : g_bad_w
         $error("tmr_irq_vec: VEC_W too narrow for the code field");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_evt;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] grant;
   logic [NUM_SRC-1:0] clr_mask;
   logic [IDX_W-1:0]   win_idx;
   logic               win_any;
   logic               service;

   // event selection per source
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_sel
         assign src_evt[c] = ch_cap_mode[c] ? ch_cap_evt[c] : ch_cmp_evt[c];
      end
   endgenerate
   assign src_evt[NUM_CH] = wrap_at_period ? cnt_at_period : cnt_at_max;

   assign pend     = flags & src_en;
   assign service  = irq_ack | vec_rd;
   assign clr_mask = grant & {NUM_SRC{service}};

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_cell
         tiv_flag_cell #(.SYNC_EVT(SYNC_EVT)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .evt    (src_evt[s]),
            .clr    (clr_mask[s]),
            .wr_en  (flag_wr_en),
            .wr_val (flag_wr_data[s]),
            .flag   (flags[s])
         );
      end
   endgenerate

   tiv_prio_enc #(.N(NUM_SRC)) u_prio (
      .req   (pend),
      .grant (grant),
      .idx   (win_idx),
      .any   (win_any)
   );

   tiv_vec_fmt #(.N(NUM_SRC), .VEC_W(VEC_W)) u_fmt (
      .any (win_any),
      .idx (win_idx),
      .vec (vec_word)
   );

   assign irq_req = win_any;

endmodule

// File: rtl/tiv_chk.sv
module tiv_chk #(
   parameter int NUM_CH = 4,
   parameter int VEC_W  = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             irq_ack,
   input logic             vec_rd,
   input logic             flag_wr_en,
   input logic             irq_req,
   input logic [VEC_W-1:0] vec_word,
   input logic [NUM_CH:0]  flags
);

   // R6
   vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
      irq_req == (vec_word != '0));

   // R5
   vec_range_chk: assert property (@(posedge clk) disable iff (rst)
      (vec_word[0] == 1'b0) && (vec_word <= VEC_W'(2 * (NUM_CH + 1))));

   // R7
   one_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !flag_wr_en |=> $onehot0($past(flags) & ~flags));

   // R8
   no_stray_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!irq_ack && !vec_rd && !flag_wr_en) |=> (($past(flags) & ~flags) == '0));

   // R11
   idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (!irq_req && !flag_wr_en) |=> (($past(flags) & ~flags) == '0));

endmodule

bind tmr_irq_vec tiv_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_tiv_chk (
   .clk        (clk),
   .rst        (rst),
   .irq_ack    (irq_ack),
   .vec_rd     (vec_rd),
   .flag_wr_en (flag_wr_en),
   .irq_req    (irq_req),
   .vec_word   (vec_word),
   .flags      (flags)
);

// File: tb/test_tmr_irq_vec.sv
module test_tmr_irq_vec;

   localparam int NCH = 4;
   localparam int NT  = 10;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NCH-1:0] ch_cap_mode = '0, ch_cap_evt = '0, ch_cmp_evt = '0;
   logic           wrap_at_period = 1'b0, cnt_at_max = 1'b0, cnt_at_period = 1'b0;
   logic [NCH:0]   src_en = '0, flag_wr_data = '0;
   logic           flag_wr_en = 1'b0, irq_ack = 1'b0, vec_rd = 1'b0;
   logic           irq_req;
   logic [15:0]    vec_word;
   logic [NCH:0]   flags;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   tmr_irq_vec #(.NUM_CH(NCH), .VEC_W(16), .SYNC_EVT(1'b1)) i_tmr_irq_vec (.*);

   // {enable, loaded flags, expected vector, flags after service}
   localparam logic [18:0] TBL [NT] = '{
      {5'h1F, 5'h1F, 4'd2,  5'h1E},
      {5'h1F, 5'h1E, 4'd4,  5'h1C},
      {5'h1F, 5'h18, 4'd8,  5'h10},
      {5'h1F, 5'h10, 4'd10, 5'h00},
      {5'h00, 5'h1F, 4'd0,  5'h1F},
      {5'h1E, 5'h01, 4'd0,  5'h01},
      {5'h14, 5'h1F, 4'd6,  5'h1B},
      {5'h10, 5'h1F, 4'd10, 5'h0F},
      {5'h1F, 5'h00, 4'd0,  5'h00},
      {5'h0A, 5'h0C, 4'd8,  5'h04}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic load(input logic [NCH:0] v);
      flag_wr_en = 1'b1; flag_wr_data = v;
      tick();
      flag_wr_en = 1'b0; flag_wr_data = '0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1 flags in reset", flags, 0);
      chk("R1 irq in reset", irq_req, 0);
      chk("R1 vec in reset", vec_word, 0);
      rst = 1'b0;
      tick();
      chk("R1 flags after reset", flags, 0);

      // table walk: R4 R5 R6, service by accept (R7) or read (R8), R11
      for (int k = 0; k < NT; k++) begin
         logic [4:0] en_v, fl_v, aft_v;
         logic [3:0] vec_v;
         {en_v, fl_v, vec_v, aft_v} = TBL[k];
         src_en = en_v;
         load(fl_v);
         chk($sformatf("R4 irq row %0d", k), irq_req, (vec_v != 0));
         chk($sformatf("R5 R6 vec row %0d", k), vec_word, {12'd0, vec_v});
         if (k % 2 == 0) irq_ack = 1'b1; else vec_rd = 1'b1;
         tick();
         irq_ack = 1'b0; vec_rd = 1'b0;
         chk($sformatf("%s flags after row %0d", (k % 2 == 0) ? "R7" : "R8", k), flags, aft_v);
      end

      // R7 request stays high while lower flags remain
      src_en = 5'h1F;
      load(5'h03);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      chk("R7 irq re-raised", irq_req, 1);
      chk("R7 next vector", vec_word, 4);
      load(5'h00);

      // R2 capture mode: compare event ignored, capture sets after two edges
      ch_cap_mode = 4'b0001;
      ch_cmp_evt[0] = 1'b1; tick(); ch_cmp_evt[0] = 1'b0; tick();
      chk("R2 cmp ignored in capture mode", flags, 0);
      ch_cap_evt[0] = 1'b1; tick(); ch_cap_evt[0] = 1'b0;
      chk("R2 not yet visible after one edge", flags, 0);
      tick();
      chk("R2 capture sets ch1", flags, 5'h01);
      // R2 compare mode on ch3
      ch_cap_evt[2] = 1'b1; tick(); ch_cap_evt[2] = 1'b0; tick();
      chk("R2 capture ignored in compare mode", flags, 5'h01);
      ch_cmp_evt[2] = 1'b1; tick(); ch_cmp_evt[2] = 1'b0; tick();
      chk("R2 compare sets ch3", flags, 5'h05);
      load(5'h00);

      // R3 wrap flag sources
      wrap_at_period = 1'b0;
      cnt_at_period = 1'b1; tick(); cnt_at_period = 1'b0; tick();
      chk("R3 period ignored in top mode", flags, 0);
      cnt_at_max = 1'b1; tick(); cnt_at_max = 1'b0; tick();
      chk("R3 top sets wrap", flags, 5'h10);
      chk("R3 wrap vector", vec_word, 10);
      load(5'h00);
      wrap_at_period = 1'b1;
      cnt_at_max = 1'b1; tick(); cnt_at_max = 1'b0; tick();
      chk("R3 top ignored in period mode", flags, 0);
      cnt_at_period = 1'b1; tick(); cnt_at_period = 1'b0; tick();
      chk("R3 period sets wrap", flags, 5'h10);
      load(5'h00);

      // R9 set wins over same-cycle accept clear
      load(5'h01);
      ch_cap_evt[0] = 1'b1; tick();
      ch_cap_evt[0] = 1'b0; irq_ack = 1'b1; tick();
      irq_ack = 1'b0;
      chk("R9 set beats accept", flags, 5'h01);
      // R9 set wins over direct write of 0
      ch_cap_evt[0] = 1'b1; tick();
      ch_cap_evt[0] = 1'b0; flag_wr_en = 1'b1; flag_wr_data = '0; tick();
      flag_wr_en = 1'b0;
      chk("R9 set beats write", flags, 5'h01);

      // R10 write overrides a same-cycle read clear
      load(5'h03);
      flag_wr_en = 1'b1; flag_wr_data = 5'h03; vec_rd = 1'b1; tick();
      flag_wr_en = 1'b0; vec_rd = 1'b0;
      chk("R10 write beats read clear", flags, 5'h03);

      // R1 reset mid-run
      rst = 1'b1; tick(); rst = 1'b0;
      chk("R1 reset clears flags", flags, 0);
      chk("R1 reset drops irq", irq_req, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule